// File: doc/BRIEF.md
# Vectored Prioritised Interrupt Controller

The controller gathers 26 interrupt request lines into a pending register and raises one of two request outputs toward a processor core: a fast request or a normal request. Per source, a mode bit picks the output. A per-source mask and one global mask keep a source from being forwarded, but they never stop its pending bit from being recorded. Software retires a pending bit by writing a 1 to the matching position of a clear register.

Normal requests go through a two-level priority tree. Four slave arbiters each take six sources. Four of those six slots in each slave have a programmable rank. The other two slots are fixed and rank below them. A master arbiter orders the four slaves by its own programmable ranks. Below every slave sit two last-resort sources: the real-time-clock line and the converter line. The single winning source is shown as a one-hot service word.

When vectoring is enabled, the block also builds the 32-bit unconditional relative branch word that a core fetching the normal-interrupt vector at 0x18 would execute. This branch lands on the winning source's own vector slot. A small register port writes and reads the control, mode, mask, priority and clear registers, and it reads back the pending and service words.

Top module: `irqv_top`

## Requirements
- R1: A source whose request line is high at a rising clock edge has its pending bit set after that edge, and the bit stays set after the request drops. The pending word (read address 6) is zero after reset.
- R2: Mask register (address 2) bits [25:0] are per-source masks, and all mask bits reset to 1. A masked source still becomes pending but drives neither request output and never appears in the service word.
- R3: Mask bit 26 is a global mask. While it is 1, both irqReq and fiqReq stay low and the service word is zero, whatever is pending.
- R4: A write to address 5 clears every pending bit whose data bit is 1. Bits written 0 are unchanged. A request present in the same cycle as its clear leaves the bit set.
- R5: Mode register (address 1) bit i = 1 sends source i to fiqReq. Bit i = 0 sends it to irqReq. Fast sources never appear in the service word.
- R6: Slave s (sources 6s..6s+5) takes rank codes from address 3 byte s, with slot k (k=0..3) at bits [8s+2k+1:8s+2k]. A lower code wins. Slots 4 and 5 rank below every programmable slot, and slot 4 ranks above slot 5. The reset value is 0xE4E4E4E4.
- R7: Address 4 bits [2s+1:2s] give slave s its master rank, where a lower code wins, and the reset value is 0xE4. Source 24 (real-time clock) and then source 25 (converter) rank below all four slaves.
- R8: The service word (port svcPend, read address 7) is one-hot with the single highest-ranked pending, unmasked, normal-mode source, or zero if there is none.
- R9: With control bit 0 (address 0) set and a winner present, vecInstr = 0xEA000000 | (((V − 0x18 − 8) >> 2) & 0xFFFFFF). Here V = 0x20 + 0x20·(i/6) + 4·(i%6) for i < 24, 0xA0 for source 24, and 0xB4 for source 25. Source 0 gives 0xEA000000.
- R10: With control bit 0 clear, or with no winner, vecInstr is the fixed branch 0xEA000000 | ((HANDLER_ADDR − 0x20) >> 2). This is 0xEA000038 at the default of 0x100.
- R11: Equal rank codes inside a slave or inside the master fall back to index order, with the lower index winning.
- R12: irqReq is high exactly when the service word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 26 | Interrupt request lines, one per source |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| irqReq | output | 1 | Normal interrupt request to the core |
| fiqReq | output | 1 | Fast interrupt request to the core |
| svcPend | output | 26 | One-hot winning normal source |
| vecInstr | output | 32 | Branch word for the normal vector fetch |

## Verification
The registers and the pending bits update on the clock edge that samples a write or a request. Everything after them is combinational. So irqReq, fiqReq, svcPend, vecInstr and rdData reflect a stimulus one edge after it is presented. The bench drives every input on a falling edge, lets exactly one rising edge pass, and samples at the next falling edge, so each result is read in the first cycle it is due. Request pulses last one cycle, so each later read of the pending word also shows that the bit is held and not just followed.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;
  localparam int NUM_SRC   = 26;
  localparam int NUM_SLV   = 4;
  localparam int SLV_SRCS  = 6;
  localparam int PROG_SLOT = 4;
  localparam int RANK_W    = 2;
  localparam int RTC_IDX   = NUM_SLV * SLV_SRCS;
  localparam int ADC_IDX   = RTC_IDX + 1;
  localparam int GLOBAL_BIT = NUM_SRC;

  typedef struct packed {
    logic ctrlWr;
    logic modeWr;
    logic maskWr;
    logic slvWr;
    logic mstWr;
    logic clrWr;
  } strobe_t;

  // Vector slot byte address for a given source index
  function automatic logic [31:0] vecAddr(input int src);
    if (src == RTC_IDX) return 32'hA0;
    if (src == ADC_IDX) return 32'hB4;
    return 32'h20 + 32'h20 * 32'(src / SLV_SRCS) + 32'd4 * 32'(src % SLV_SRCS);
  endfunction
endpackage

// File: rtl/irqv_ctrl.sv
`timescale 1ns/1ps
module irqv_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output irqv_pkg::strobe_t stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        ADDR_W'(0): stb.ctrlWr = 1'b1;
        ADDR_W'(1): stb.modeWr = 1'b1;
        ADDR_W'(2): stb.maskWr = 1'b1;
        ADDR_W'(3): stb.slvWr  = 1'b1;
        ADDR_W'(4): stb.mstWr  = 1'b1;
        ADDR_W'(5): stb.clrWr  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqv_prio.sv
`timescale 1ns/1ps
module irqv_prio
  import irqv_pkg::*;
(
  input  logic [NUM_SRC-1:0]              cand,
  input  logic [NUM_SLV*PROG_SLOT*RANK_W-1:0] slvRank,
  input  logic [NUM_SLV*RANK_W-1:0]       mstRank,
  output logic [NUM_SRC-1:0]              winner
);
  localparam int SLV_BITS = PROG_SLOT * RANK_W;

  // Returns {hit, slot[2:0]}; key {code,slot} keeps ties in index order
  function automatic logic [3:0] pickSlot(input logic [SLV_SRCS-1:0] c,
                                          input logic [SLV_BITS-1:0] codes);
    logic [3:0] res;
    logic [3:0] bestKey;
    logic [3:0] key;
    res = '0;
    bestKey = '1;
    for (int k = 0; k < PROG_SLOT; k++) begin
      key = {codes[RANK_W*k +: RANK_W], 2'(k)};
      if (c[k] && (!res[3] || key < bestKey)) begin
        res = {1'b1, 3'(k)};
        bestKey = key;
      end
    end
    if (!res[3]) begin
      if (c[4])      res = 4'b1100;
      else if (c[5]) res = 4'b1101;
    end
    return res;
  endfunction

  function automatic logic [2:0] pickSlave(input logic [NUM_SLV-1:0] h,
                                           input logic [NUM_SLV*RANK_W-1:0] codes);
    logic [2:0] res;
    logic [3:0] bestKey;
    logic [3:0] key;
    res = '0;
    bestKey = '1;
    for (int s = 0; s < NUM_SLV; s++) begin
      key = {codes[RANK_W*s +: RANK_W], 2'(s)};
      if (h[s] && (!res[2] || key < bestKey)) begin
        res = {1'b1, 2'(s)};
        bestKey = key;
      end
    end
    return res;
  endfunction

  logic [NUM_SLV-1:0] slvHit;
  logic [2:0]         slvIdx [NUM_SLV];
  logic [2:0]         mstSel;

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slave
    logic [3:0] pick;
    assign pick      = pickSlot(cand[SLV_SRCS*s +: SLV_SRCS], slvRank[SLV_BITS*s +: SLV_BITS]);
    assign slvHit[s] = pick[3];
    assign slvIdx[s] = pick[2:0];
  end

  assign mstSel = pickSlave(slvHit, mstRank);

  always_comb begin
    winner = '0;
    if (mstSel[2])
      winner[SLV_SRCS * int'(mstSel[1:0]) + int'(slvIdx[mstSel[1:0]])] = 1'b1;
    else if (cand[RTC_IDX])
      winner[RTC_IDX] = 1'b1;
    else if (cand[ADC_IDX])
      winner[ADC_IDX] = 1'b1;
  end
endmodule

// File: rtl/irqv_datapath.sv
`timescale 1ns/1ps
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int          ADDR_W       = 3,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] HANDLER_ADDR = 32'h100
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq,
  output logic               fiqReq,
  output logic [NUM_SRC-1:0] svcPend,
  output logic [31:0]        vecInstr
);
  localparam int SLV_W = NUM_SLV * PROG_SLOT * RANK_W;
  localparam int MST_W = NUM_SLV * RANK_W;
  localparam logic [31:0] BRANCH_OP  = 32'hEA000000;
  localparam logic [31:0] VEC_FETCH  = 32'h18;
  localparam logic [31:0] PIPE_AHEAD = 32'h8;
  localparam logic [31:0] PLAIN_INSTR =
    BRANCH_OP | (((HANDLER_ADDR - VEC_FETCH - PIPE_AHEAD) >> 2) & 32'h00FFFFFF);

  logic               vecEn;
  logic [NUM_SRC-1:0] modeReg;
  logic [NUM_SRC:0]   maskReg;
  logic [SLV_W-1:0]   slvReg;
  logic [MST_W-1:0]   mstReg;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clrBits;
  logic [NUM_SRC-1:0] live;
  logic [NUM_SRC-1:0] normCand;
  logic [NUM_SRC-1:0] fastCand;

  assign clrBits = stb.clrWr ? wrData[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecEn   <= 1'b0;
      modeReg <= '0;
      maskReg <= '1;
      slvReg  <= {NUM_SLV{8'hE4}};
      mstReg  <= 8'hE4;
      pend    <= '0;
    end else begin
      if (stb.ctrlWr) vecEn   <= wrData[0];
      if (stb.modeWr) modeReg <= wrData[NUM_SRC-1:0];
      if (stb.maskWr) maskReg <= wrData[NUM_SRC:0];
      if (stb.slvWr)  slvReg  <= wrData[SLV_W-1:0];
      if (stb.mstWr)  mstReg  <= wrData[MST_W-1:0];
      pend <= (pend & ~clrBits) | reqIn;
    end
  end

  assign live     = pend & ~maskReg[NUM_SRC-1:0] & {NUM_SRC{~maskReg[GLOBAL_BIT]}};
  assign normCand = live & ~modeReg;
  assign fastCand = live & modeReg;
  assign irqReq   = |normCand;
  assign fiqReq   = |fastCand;

  irqv_prio u_prio (
    .cand    (normCand),
    .slvRank (slvReg),
    .mstRank (mstReg),
    .winner  (svcPend)
  );

  logic [31:0] winAddr;
  always_comb begin
    winAddr = VEC_FETCH + PIPE_AHEAD;
    for (int i = 0; i < NUM_SRC; i++)
      if (svcPend[i]) winAddr = vecAddr(i);
  end

  always_comb begin
    if (vecEn && (svcPend != '0))
      vecInstr = BRANCH_OP | (((winAddr - VEC_FETCH - PIPE_AHEAD) >> 2) & 32'h00FFFFFF);
    else
      vecInstr = PLAIN_INSTR;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_W'(0): rdData = DATA_W'(vecEn);
      ADDR_W'(1): rdData = DATA_W'(modeReg);
      ADDR_W'(2): rdData = DATA_W'(maskReg);
      ADDR_W'(3): rdData = DATA_W'(slvReg);
      ADDR_W'(4): rdData = DATA_W'(mstReg);
      ADDR_W'(6): rdData = DATA_W'(pend);
      ADDR_W'(7): rdData = DATA_W'(svcPend);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqv_top.sv
`timescale 1ns/1ps
module irqv_top #(
  parameter int          ADDR_W       = 3,
  parameter int          DATA_W       = 32,
  parameter logic [31:0] HANDLER_ADDR = 32'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [25:0]       reqIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic              fiqReq,
  output logic [25:0]       svcPend,
  output logic [31:0]       vecInstr
);
  irqv_pkg::strobe_t stb;

  irqv_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  irqv_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HANDLER_ADDR(HANDLER_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addr     (addr),
    .wrData   (wrData),
    .reqIn    (reqIn),
    .rdData   (rdData),
    .irqReq   (irqReq),
    .fiqReq   (fiqReq),
    .svcPend  (svcPend),
    .vecInstr (vecInstr)
  );
endmodule

// File: rtl/irqv_chk.sv
`timescale 1ns/1ps
module irqv_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [25:0]       reqIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqReq,
  input logic              fiqReq,
  input logic [25:0]       svcPend,
  input logic [25:0]       pend,
  input logic [26:0]       maskReg,
  input logic [25:0]       modeReg
);
  logic [25:0] clrSeen;
  assign clrSeen = (wrEn && addr == ADDR_W'(5)) ? wrData[25:0] : '0;

  // R1: a sampled request is pending one edge later
  a_r1_req_sets_pend: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pend & $past(reqIn)) == $past(reqIn)));

  // R4: a pending bit only falls when a clear wrote 1 to it
  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((~pend & $past(pend) & ~$past(clrSeen)) == '0));

  // R3: global mask silences both request outputs
  a_r3_global_quiet: assert property (@(posedge clk) disable iff (!rstN)
    maskReg[26] |-> (!irqReq && !fiqReq && svcPend == '0));

  // R8: one winner at most, drawn from live normal-mode sources
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(svcPend));
  a_r8_legal_winner: assert property (@(posedge clk) disable iff (!rstN)
    (svcPend & ~(pend & ~maskReg[25:0] & ~modeReg)) == '0);

  // R12: normal request agrees with the priority tree result
  a_r12_irq_matches: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (svcPend != '0));
endmodule

bind irqv_top irqv_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqIn   (reqIn),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .irqReq  (irqReq),
  .fiqReq  (fiqReq),
  .svcPend (svcPend),
  .pend    (u_dp.pend),
  .maskReg (u_dp.maskReg),
  .modeReg (u_dp.modeReg)
);

// File: tb/sim_irqv_top.sv
`timescale 1ns/1ps
module sim_irqv_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [25:0] reqIn = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqReq, fiqReq;
  logic [25:0] svcPend;
  logic [31:0] vecInstr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irqv_top u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqReq(irqReq), .fiqReq(fiqReq),
    .svcPend(svcPend), .vecInstr(vecInstr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [25:0] bits);
    @(negedge clk);
    reqIn = bits;
    @(negedge clk);
    reqIn = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  function automatic logic [31:0] brTo(input logic [31:0] va);
    return 32'hEA000000 | (((va - 32'h20) >> 2) & 32'h00FFFFFF);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    check("R12 reset irqReq", 32'(irqReq), 0);
    check("R5 reset fiqReq", 32'(fiqReq), 0);
    rd(3'd6, v); check("R1 reset pending", v, 0);
    rd(3'd2, v); check("R2 reset mask", v, 32'h07FFFFFF);
    rd(3'd3, v); check("R6 reset slave ranks", v, 32'hE4E4E4E4);
    rd(3'd4, v); check("R7 reset master ranks", v, 32'hE4);
    check("R10 reset instr", vecInstr, 32'hEA000038);
  endtask

  task automatic t_mask_mode();
    logic [31:0] v;
    pulse(26'h8);
    rd(3'd6, v); check("R1 pending held after pulse", v, 32'h8);
    check("R2 masked no irq", 32'(irqReq), 0);
    wr(3'd2, 32'h07FFFFF7);
    check("R3 global mask blocks irq", 32'(irqReq), 0);
    check("R3 global mask svc zero", 32'(svcPend), 0);
    wr(3'd2, 32'h03FFFFF7);
    check("R12 unmasked irq", 32'(irqReq), 1);
    check("R8 svc source 3", 32'(svcPend), 32'h8);
    rd(3'd7, v); check("R8 svc readback", v, 32'h8);
    check("R10 non-vectored instr", vecInstr, 32'hEA000038);
    wr(3'd0, 32'h1);
    check("R9 vectored src3", vecInstr, 32'hEA000003);
    wr(3'd1, 32'h8);
    check("R5 fast route fiq", 32'(fiqReq), 1);
    check("R5 fast route no irq", 32'(irqReq), 0);
    check("R5 fast not in svc", 32'(svcPend), 0);
    check("R10 no winner instr", vecInstr, 32'hEA000038);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd5, 32'h0);
    rd(3'd6, v); check("R4 write zero keeps", v, 32'h8);
    wr(3'd5, 32'h8);
    rd(3'd6, v); check("R4 write one clears", v, 32'h0);
    check("R12 cleared irq low", 32'(irqReq), 0);
    @(negedge clk);
    reqIn = 26'h20; wrEn = 1'b1; addr = 3'd5; wrData = 32'h20;
    @(negedge clk);
    reqIn = '0; wrEn = 1'b0; wrData = '0;
    rd(3'd6, v); check("R4 request beats clear", v, 32'h20);
    wr(3'd5, 32'h3FFFFFF);
  endtask

  task automatic t_master();
    wr(3'd2, 32'h0);
    pulse(26'h2000084);
    check("R7 default slave0 wins", 32'(svcPend), 32'h4);
    check("R9 vector src2", vecInstr, 32'hEA000002);
    wr(3'd4, 32'hE1);
    check("R7 slave1 promoted", 32'(svcPend), 32'h80);
    check("R9 vector src7", vecInstr, brTo(32'h44));
    wr(3'd5, 32'h84);
    check("R7 converter last", 32'(svcPend), 32'h2000000);
    check("R9 vector converter", vecInstr, brTo(32'hB4));
    wr(3'd5, 32'h3FFFFFF);
    wr(3'd4, 32'hE4);
    pulse(26'h3800000);
    check("R7 slave3 fixed beats rtc", 32'(svcPend), 32'h800000);
    check("R9 vector src23", vecInstr, brTo(32'h94));
    wr(3'd5, 32'h800000);
    check("R7 rtc before converter", 32'(svcPend), 32'h1000000);
    check("R9 vector rtc", vecInstr, brTo(32'hA0));
    wr(3'd5, 32'h3FFFFFF);
  endtask

  task automatic t_slave();
    pulse(26'h33);
    check("R9 first source word", vecInstr, 32'hEA000000);
    check("R6 default slot0", 32'(svcPend), 32'h1);
    wr(3'd3, 32'hE4E4E493);
    check("R6 programmed slot1", 32'(svcPend), 32'h2);
    check("R9 vector src1", vecInstr, 32'hEA000001);
    wr(3'd5, 32'h3);
    check("R6 fixed slot4", 32'(svcPend), 32'h10);
    check("R9 vector src4", vecInstr, 32'hEA000004);
    wr(3'd5, 32'h10);
    check("R6 fixed slot5 last", 32'(svcPend), 32'h20);
    wr(3'd5, 32'h3FFFFFF);
    wr(3'd3, 32'hE4E4E4F5);
    pulse(26'h3);
    check("R11 duplicate rank index order", 32'(svcPend), 32'h1);
    wr(3'd4, 32'hE0);
    pulse(26'h40);
    check("R11 master duplicate rank", 32'(svcPend), 32'h1);
    wr(3'd5, 32'h3FFFFFF);
    check("R12 all cleared", 32'(irqReq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mask_mode();
    t_clear();
    t_master();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule